// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block holds the running date and time of a real-time clock: seconds, minutes, hours, day of week, day of month, month and a three-digit year. Every field is kept directly in BCD, so no conversion is needed when the values are read. A divider counts cycles of a slow reference clock and produces one event per second. Each event advances the seconds and ripples carries upward through the calendar. Month lengths and the full Gregorian leap-year rule are applied at the day carry.

Software loads a field through a narrow write port: a field select, a data word and a strobe. A load is accepted only while the run enable is high. The current value of every field is always on the outputs, so an alarm comparator can watch them and a bus wrapper can read them. Dropping the run enable freezes the time. Raising it starts a fresh one-second interval.

Top module: `bcd_calendar`

## Requirements
- R1: The divider produces `second_tick`, and the time advances by one second, exactly DIV_CYCLES reference cycles (default 32768) after the clock edge that samples `run_en` rising. After that it advances every DIV_CYCLES cycles.
- R2: While `run_en` is low the divider is idle, `second_tick` stays low and the time does not change. A new rising edge of `run_en` restarts a full interval.
- R3: Seconds wrap from 59 to 00 and carry into minutes. Minutes wrap from 59 to 00 and carry into hours. Hours wrap from 23 to 00 and carry into the day.
- R4: On a day carry, day of week counts 0 to 6 and wraps to 0, and day of month increments.
- R5: Day of month returns to 01 and carries into the month after day 30 of April, June, September and November, after day 31 of the other long months, and after day 28 of February. In a leap year February runs to day 29. The full year is YEAR_BASE (default 1900) plus the BCD year, and it is a leap year when it is divisible by 4 and not by 100, or when it is divisible by 400.
- R6: After month 12 the month returns to 01 and the year increments. The year is three BCD digits, with hundreds in bits 11:8 and tens and units in bits 7:0, and it wraps from 999 to 000.
- R7: A write with `wr_en` high loads one field from `wr_data` in BCD. `wr_sel` selects the field: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month, 6 year. The month is read and written as BCD 01 to 12 and is held internally as 0 to 11.
- R8: A write is ignored while `run_en` is low, and no field changes in a cycle with neither a tick nor an accepted write.
- R9: When a write and a one-second event fall in the same cycle, the written field takes the written value. The other fields still advance, including any carry out of the old value of the written field.
- R10: Reset gives 00:00:00, day of week 0, day 01, month 01 and year 000, with the divider idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Clock run enable; also gates writes |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 3 | Field select for writes |
| wr_data | input | 12 | BCD write data |
| second_tick | output | 1 | One-cycle pulse on each one-second event |
| sec_bcd | output | 8 | Seconds, BCD |
| min_bcd | output | 8 | Minutes, BCD |
| hour_bcd | output | 8 | Hours, BCD |
| wday_bcd | output | 8 | Day of week, 0 to 6 |
| mday_bcd | output | 8 | Day of month, BCD |
| mon_bcd | output | 8 | Month, BCD 01 to 12 |
| year_bcd | output | 12 | Three-digit BCD year |

## Verification
Several rules are checked on every cycle: the idle divider never ticks, ticks are never adjacent, the time holds still without a tick or an accepted write, seconds, weekday and end-of-year wraps, and a colliding write winning its field. Only the bench scenarios show the exact one-second spacing after enable, the lengths of each month under the three leap-year cases, the digit carries of the year, and the write-ignore behaviour seen at the outputs.

// File: rtl/cal_pkg.sv
package cal_pkg;

    typedef enum logic [2:0] {
        FLD_SEC  = 3'd0,
        FLD_MIN  = 3'd1,
        FLD_HOUR = 3'd2,
        FLD_WDAY = 3'd3,
        FLD_MDAY = 3'd4,
        FLD_MON  = 3'd5,
        FLD_YEAR = 3'd6
    } field_e;

    typedef struct packed {
        logic [7:0]  sec;
        logic [7:0]  min;
        logic [7:0]  hour;
        logic [2:0]  wday;
        logic [7:0]  mday;
        logic [3:0]  mon;   // 0..11
        logic [11:0] year;
    } cal_t;

    function automatic logic [7:0] bcd_inc8(input logic [7:0] v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic [11:0] bcd_inc12(input logic [11:0] v);
        if (v[7:0] == 8'h99) return {(v[11:8] >= 4'd9) ? 4'd0 : v[11:8] + 4'd1, 8'h00};
        return {v[11:8], bcd_inc8(v[7:0])};
    endfunction

    function automatic logic [7:0] bcd_to_bin8(input logic [7:0] v);
        return 8'(v[7:4]) * 8'd10 + 8'(v[3:0]);
    endfunction

    function automatic logic [7:0] bin_to_bcd8(input logic [7:0] v);
        logic [7:0] t;
        t = v / 8'd10;
        return {t[3:0], 4'(v % 8'd10)};
    endfunction

endpackage

// File: rtl/cal_sec_div.sv
module cal_sec_div #(
    parameter int unsigned DIV_CYCLES = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int unsigned CW = (DIV_CYCLES > 1) ? $clog2(DIV_CYCLES) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(DIV_CYCLES - 1);

    typedef struct packed {
        logic          run;
        logic          en_prev;
        logic [CW-1:0] cnt;
    } div_t;

    div_t div_d, div_q;

    always_comb begin
        div_d         = div_q;
        div_d.en_prev = en;
        tick          = div_q.run && (div_q.cnt == '0);
        if (!en) begin
            div_d.run = 1'b0;
            div_d.cnt = '0;
        end else if (!div_q.en_prev) begin
            div_d.run = 1'b1;
            div_d.cnt = RELOAD;
        end else if (div_q.run) begin
            div_d.cnt = tick ? RELOAD : div_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    AST_IDLE_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !tick); // R2
    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R1

endmodule

// File: rtl/cal_month_len.sv
module cal_month_len #(
    parameter int unsigned YEAR_BASE = 1900
) (
    input  logic [3:0]  mon,
    input  logic [11:0] year_bcd,
    output logic [7:0]  days_bcd
);
    logic [15:0] full_year;
    logic        leap;

    always_comb begin
        full_year = 16'(YEAR_BASE)
                  + 16'(year_bcd[11:8]) * 16'd100
                  + 16'(year_bcd[7:4]) * 16'd10
                  + 16'(year_bcd[3:0]);
        leap = (full_year % 16'd4 == 16'd0) &&
               ((full_year % 16'd100 != 16'd0) || (full_year % 16'd400 == 16'd0));
        case (mon)
            4'd1:                      days_bcd = leap ? 8'h29 : 8'h28;
            4'd3, 4'd5, 4'd8, 4'd10:   days_bcd = 8'h30;
            default:                   days_bcd = 8'h31;
        endcase
    end

endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
    import cal_pkg::*;
#(
    parameter int unsigned DIV_CYCLES = 32768,
    parameter int unsigned YEAR_BASE  = 1900
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        run_en,
    input  logic        wr_en,
    input  logic [2:0]  wr_sel,
    input  logic [11:0] wr_data,
    output logic        second_tick,
    output logic [7:0]  sec_bcd,
    output logic [7:0]  min_bcd,
    output logic [7:0]  hour_bcd,
    output logic [7:0]  wday_bcd,
    output logic [7:0]  mday_bcd,
    output logic [7:0]  mon_bcd,
    output logic [11:0] year_bcd
);
    localparam cal_t RESET_TIME = '{sec: 8'h00, min: 8'h00, hour: 8'h00, wday: 3'd0,
                                    mday: 8'h01, mon: 4'd0, year: 12'h000};

    cal_t       tm_d, tm_q;
    logic [7:0] month_days;
    logic       wr_ok;
    logic       c_sec, c_min, c_hour, c_mday;

    cal_sec_div #(.DIV_CYCLES(DIV_CYCLES)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (run_en),
        .tick (second_tick)
    );

    cal_month_len #(.YEAR_BASE(YEAR_BASE)) u_mlen (
        .mon     (tm_q.mon),
        .year_bcd(tm_q.year),
        .days_bcd(month_days)
    );

    always_comb begin
        tm_d   = tm_q;
        wr_ok  = wr_en && run_en;
        c_sec  = second_tick && (tm_q.sec >= 8'h59);
        c_min  = c_sec && (tm_q.min >= 8'h59);
        c_hour = c_min && (tm_q.hour >= 8'h23);
        c_mday = c_hour && (tm_q.mday >= month_days);

        if (second_tick) tm_d.sec = c_sec ? 8'h00 : bcd_inc8(tm_q.sec);
        if (c_sec)       tm_d.min = c_min ? 8'h00 : bcd_inc8(tm_q.min);
        if (c_min)       tm_d.hour = c_hour ? 8'h00 : bcd_inc8(tm_q.hour);
        if (c_hour) begin
            tm_d.wday = (tm_q.wday >= 3'd6) ? 3'd0 : tm_q.wday + 3'd1;
            tm_d.mday = c_mday ? 8'h01 : bcd_inc8(tm_q.mday);
        end
        if (c_mday) begin
            if (tm_q.mon >= 4'd11) begin
                tm_d.mon  = 4'd0;
                tm_d.year = bcd_inc12(tm_q.year);
            end else begin
                tm_d.mon  = tm_q.mon + 4'd1;
            end
        end

        if (wr_ok) begin
            case (field_e'(wr_sel))
                FLD_SEC:  tm_d.sec  = {1'b0, wr_data[6:0]};
                FLD_MIN:  tm_d.min  = {1'b0, wr_data[6:0]};
                FLD_HOUR: tm_d.hour = {2'b0, wr_data[5:0]};
                FLD_WDAY: tm_d.wday = wr_data[2:0];
                FLD_MDAY: tm_d.mday = {2'b0, wr_data[5:0]};
                FLD_MON:  tm_d.mon  = 4'(bcd_to_bin8({3'b0, wr_data[4:0]}) - 8'd1);
                FLD_YEAR: tm_d.year = wr_data;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tm_q <= RESET_TIME;
        else        tm_q <= tm_d;
    end

    assign sec_bcd  = tm_q.sec;
    assign min_bcd  = tm_q.min;
    assign hour_bcd = tm_q.hour;
    assign wday_bcd = {5'b0, tm_q.wday};
    assign mday_bcd = tm_q.mday;
    assign mon_bcd  = bin_to_bcd8(8'(tm_q.mon) + 8'd1);
    assign year_bcd = tm_q.year;

    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (second_tick && !wr_en && sec_bcd == 8'h59) |=> (sec_bcd == 8'h00)); // R3
    AST_WDAY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (second_tick && !wr_en && sec_bcd == 8'h59 && min_bcd == 8'h59 &&
         hour_bcd == 8'h23 && wday_bcd == 8'h06) |=> (wday_bcd == 8'h00)); // R4
    AST_YEAR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (second_tick && !wr_en && sec_bcd == 8'h59 && min_bcd == 8'h59 &&
         hour_bcd == 8'h23 && mday_bcd == 8'h31 && mon_bcd == 8'h12 &&
         year_bcd == 12'h999) |=>
        (year_bcd == 12'h000 && mon_bcd == 8'h01 && mday_bcd == 8'h01)); // R6
    AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!second_tick && !(wr_en && run_en)) |=> $stable(tm_q)); // R8
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && wr_en && wr_sel == 3'd0 && second_tick) |=>
        (sec_bcd == {1'b0, $past(wr_data[6:0])})); // R9

endmodule

// File: tb/tb_bcd_calendar.sv
module tb_bcd_calendar;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = 3'd0;
    logic [11:0] wr_data = 12'h000;
    logic        second_tick;
    logic [7:0]  sec_bcd, min_bcd, hour_bcd, wday_bcd, mday_bcd, mon_bcd;
    logic [11:0] year_bcd;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    string       tag_q[$];
    logic [59:0] val_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    bcd_calendar #(.DIV_CYCLES(DIV), .YEAR_BASE(1900)) dut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .second_tick(second_tick),
        .sec_bcd(sec_bcd), .min_bcd(min_bcd), .hour_bcd(hour_bcd),
        .wday_bcd(wday_bcd), .mday_bcd(mday_bcd), .mon_bcd(mon_bcd),
        .year_bcd(year_bcd)
    );

    function automatic logic [59:0] pack(input logic [7:0] h, input logic [7:0] m,
        input logic [7:0] s, input logic [7:0] w, input logic [7:0] d,
        input logic [7:0] mo, input logic [11:0] y);
        return {y, mo, d, w, h, m, s};
    endfunction

    // driver side: push an expected snapshot
    task automatic expect_t(input string tag, input logic [7:0] h, input logic [7:0] m,
        input logic [7:0] s, input logic [7:0] w, input logic [7:0] d,
        input logic [7:0] mo, input logic [11:0] y);
        tag_q.push_back(tag);
        val_q.push_back(pack(h, m, s, w, d, mo, y));
    endtask

    // monitor: pops and compares away from the clock edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (tag_q.size() > 0) begin
                string       t;
                logic [59:0] e, g;
                t = tag_q.pop_front();
                e = val_q.pop_front();
                g = {year_bcd, mon_bcd, mday_bcd, wday_bcd, hour_bcd, min_bcd, sec_bcd};
                checks++;
                if (g !== e) begin
                    errors++;
                    $display("FAIL %s got=%h exp=%h", t, g, e);
                end
            end
        end
    end

    task automatic wr(input logic [2:0] sel, input logic [11:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // restarts the divider and loads all fields; returns 7 cycles after the load edge
    task automatic load_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s,
        input logic [7:0] w, input logic [7:0] d, input logic [7:0] mo, input logic [11:0] y);
        run_en = 1'b0;
        repeat (2) @(negedge clk);
        run_en = 1'b1;
        wr(3'd0, {4'h0, s});
        wr(3'd1, {4'h0, m});
        wr(3'd2, {4'h0, h});
        wr(3'd3, {4'h0, w});
        wr(3'd4, {4'h0, d});
        wr(3'd5, {4'h0, mo});
        wr(3'd6, y);
    endtask

    // load, then wait until just after the first one-second event
    task automatic roll(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s,
        input logic [7:0] w, input logic [7:0] d, input logic [7:0] mo, input logic [11:0] y);
        load_time(h, m, s, w, d, mo, y);
        repeat (DIV - 6) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_t("R10 reset state", 8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 12'h000);

        // R8: write while disabled has no effect
        wr(3'd0, 12'h030);
        wr(3'd5, 12'h007);
        repeat (DIV + 4) @(negedge clk);
        expect_t("R8 write ignored while disabled / R2 idle", 8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 12'h000);

        // R7 load and R1 exact interval
        load_time(8'h12, 8'h34, 8'h56, 8'h03, 8'h15, 8'h06, 12'h123);
        expect_t("R7 fields loaded", 8'h12, 8'h34, 8'h56, 8'h03, 8'h15, 8'h06, 12'h123);
        repeat (DIV - 7) @(negedge clk);
        expect_t("R1 no advance before interval", 8'h12, 8'h34, 8'h56, 8'h03, 8'h15, 8'h06, 12'h123);
        @(negedge clk);
        expect_t("R1 advance at interval", 8'h12, 8'h34, 8'h57, 8'h03, 8'h15, 8'h06, 12'h123);
        repeat (DIV) @(negedge clk);
        expect_t("R1 periodic advance", 8'h12, 8'h34, 8'h58, 8'h03, 8'h15, 8'h06, 12'h123);

        // R2: disable freezes, re-enable restarts a full interval
        run_en = 1'b0;
        repeat (3 * DIV) @(negedge clk);
        expect_t("R2 frozen while disabled", 8'h12, 8'h34, 8'h58, 8'h03, 8'h15, 8'h06, 12'h123);
        run_en = 1'b1;
        repeat (DIV) @(negedge clk);
        expect_t("R2 full interval after restart", 8'h12, 8'h34, 8'h58, 8'h03, 8'h15, 8'h06, 12'h123);
        @(negedge clk);
        expect_t("R2 advance after restart", 8'h12, 8'h34, 8'h59, 8'h03, 8'h15, 8'h06, 12'h123);

        // R3 carries
        roll(8'h10, 8'h59, 8'h59, 8'h02, 8'h11, 8'h07, 12'h123);
        expect_t("R3 minute into hour", 8'h11, 8'h00, 8'h00, 8'h02, 8'h11, 8'h07, 12'h123);
        roll(8'h08, 8'h21, 8'h59, 8'h02, 8'h11, 8'h07, 12'h123);
        expect_t("R3 second into minute", 8'h08, 8'h22, 8'h00, 8'h02, 8'h11, 8'h07, 12'h123);

        // R4 day carry and weekday wrap
        roll(8'h23, 8'h59, 8'h59, 8'h06, 8'h09, 8'h05, 12'h123);
        expect_t("R4 weekday wrap", 8'h00, 8'h00, 8'h00, 8'h00, 8'h10, 8'h05, 12'h123);

        // R5 month lengths and leap rule (base 1900)
        roll(8'h23, 8'h59, 8'h59, 8'h01, 8'h28, 8'h02, 12'h100);
        expect_t("R5 Feb 28 of 2000 leap", 8'h00, 8'h00, 8'h00, 8'h02, 8'h29, 8'h02, 12'h100);
        roll(8'h23, 8'h59, 8'h59, 8'h01, 8'h29, 8'h02, 12'h100);
        expect_t("R5 Feb 29 of 2000 end", 8'h00, 8'h00, 8'h00, 8'h02, 8'h01, 8'h03, 12'h100);
        roll(8'h23, 8'h59, 8'h59, 8'h01, 8'h28, 8'h02, 12'h101);
        expect_t("R5 Feb 28 of 2001 end", 8'h00, 8'h00, 8'h00, 8'h02, 8'h01, 8'h03, 12'h101);
        roll(8'h23, 8'h59, 8'h59, 8'h01, 8'h28, 8'h02, 12'h000);
        expect_t("R5 Feb 28 of 1900 end", 8'h00, 8'h00, 8'h00, 8'h02, 8'h01, 8'h03, 12'h000);
        roll(8'h23, 8'h59, 8'h59, 8'h01, 8'h28, 8'h02, 12'h200);
        expect_t("R5 Feb 28 of 2100 end", 8'h00, 8'h00, 8'h00, 8'h02, 8'h01, 8'h03, 12'h200);
        roll(8'h23, 8'h59, 8'h59, 8'h01, 8'h28, 8'h02, 12'h104);
        expect_t("R5 Feb 28 of 2004 leap", 8'h00, 8'h00, 8'h00, 8'h02, 8'h29, 8'h02, 12'h104);
        roll(8'h23, 8'h59, 8'h59, 8'h04, 8'h30, 8'h04, 12'h123);
        expect_t("R5 April 30 end", 8'h00, 8'h00, 8'h00, 8'h05, 8'h01, 8'h05, 12'h123);
        roll(8'h23, 8'h59, 8'h59, 8'h04, 8'h30, 8'h07, 12'h123);
        expect_t("R5 July 30 not end", 8'h00, 8'h00, 8'h00, 8'h05, 8'h31, 8'h07, 12'h123);

        // R6 year carries
        roll(8'h23, 8'h59, 8'h59, 8'h03, 8'h31, 8'h12, 12'h099);
        expect_t("R6 year 099 to 100", 8'h00, 8'h00, 8'h00, 8'h04, 8'h01, 8'h01, 12'h100);
        roll(8'h23, 8'h59, 8'h59, 8'h03, 8'h31, 8'h12, 12'h999);
        expect_t("R6 year 999 wraps", 8'h00, 8'h00, 8'h00, 8'h04, 8'h01, 8'h01, 12'h000);

        // R9 write colliding with the one-second event
        load_time(8'h05, 8'h00, 8'h59, 8'h01, 8'h02, 8'h03, 12'h045);
        repeat (DIV - 7) @(negedge clk);
        wr(3'd0, 12'h010);
        expect_t("R9 write wins, carry kept", 8'h05, 8'h01, 8'h10, 8'h01, 8'h02, 8'h03, 12'h045);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule